// File: doc/BRIEF.md
# Fractional Sample Strobe Generator

This block turns one of two master tick streams into a slower audio sample strobe. The ratio is fractional. A master tick is a one-cycle enable that arrives at either the 44.1 kHz family rate or the 48 kHz family rate. On every tick of the chosen master, an accumulator adds a small increment. Each time the running sum reaches a modulus, the modulus is taken off and the block emits a single-cycle sample strobe. The average output rate is therefore increment × master ÷ modulus.

Software sets the block up through two write ports.

- **Selector register:** chooses the master family.
- **Rate register:** packs the increment with a derived form of the modulus.

To obtain a rate, software normally uses an increment of 4 and a modulus of 4 × master ÷ rate. It picks whichever master divides more evenly by the wanted rate. The block treats a nonsensical pair as "off" and never emits a strobe for it. Examples are a zero modulus, or an increment larger than the modulus.

Top module: `sclk_frac_gen`

## Requirements
- R1: While reset is asserted and after its release, the strobe is low, the accumulator is zero, the selector bit is 0 and the rate register is all zeros. Together these give increment 0 and modulus 0xFFFF, so no strobe appears until the block is reprogrammed.
- R2: Bit 0 of the selector register picks the master. A value of 1 means the tick_44k input is counted and tick_48k is ignored. A value of 0 means tick_48k is counted and tick_44k is ignored. Selector bits 15:1 have no effect.
- R3: The rate register holds the increment in bits 15:0. Bits 31:16 hold (increment − modulus − 1) as a 16-bit two's-complement value. The block recovers the modulus as increment − bits[31:16] − 1, computed modulo 2^16.
- R4: On each cycle in which the selected tick is high, the block is enabled and no write occurs, the accumulator adds the increment. If the sum is at least the modulus, the modulus is subtracted and strobe_o is high for exactly the next cycle. Otherwise the sum is kept and strobe_o stays low.
- R5: From a cleared accumulator, N counted ticks produce floor(N × increment ÷ modulus) strobes. For example, increment 4 and modulus 24 give one strobe every 6 ticks.
- R6: A write to either register clears the accumulator to zero. A tick in the cycle of the write is not counted. The new settings apply from the next cycle.
- R7: When the modulus is zero, or the increment exceeds the modulus, strobe_o never goes high.
- R8: When increment equals modulus, every counted tick yields a strobe, so back-to-back ticks give back-to-back strobe cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_44k | input | 1 | One-cycle tick of the 44.1 kHz master family |
| tick_48k | input | 1 | One-cycle tick of the 48 kHz master family |
| sel_we | input | 1 | Write enable of the selector register |
| sel_wdata | input | 16 | Selector write data; bit 0 picks the master |
| rate_we | input | 1 | Write enable of the rate register |
| rate_wdata | input | 32 | Rate write data: increment in 15:0, increment − modulus − 1 in 31:16 |
| strobe_o | output | 1 | One-cycle sample strobe |

## Verification
Register writes take effect at the clock edge that samples them. A tick sampled at edge k shows its strobe during the cycle after edge k, because there is one register stage between the tick and strobe_o.

The bench drives every input at the falling edge. It advances its reference model for that edge and compares strobe_o one nanosecond after the following rising edge. Every cycle is therefore checked exactly at the edge where its result is due, including the write cycles that must swallow a tick.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // Master family picked by bit 0 of the selector register
    typedef enum logic {
        FAM_48K = 1'b0,
        FAM_44K = 1'b1
    } fam_e;

    localparam int unsigned SEL_BIT = 0;

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
    import sclk_pkg::*;
#(
    parameter int unsigned FLD_W = 16,
    parameter int unsigned SEL_W = 16,
    localparam int unsigned RATE_W = 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output fam_e              fam_o,
    output logic [FLD_W-1:0]  inc_o,
    output logic [FLD_W-1:0]  mod_o,
    output logic              en_o,
    output logic              clr_o
);

    typedef struct packed {
        fam_e             fam;
        logic [FLD_W-1:0] inc;
        logic [FLD_W-1:0] neg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sel_we) begin
            cfg_d.fam = fam_e'(sel_wdata[SEL_BIT]);
        end
        if (rate_we) begin
            cfg_d.inc = rate_wdata[FLD_W-1:0];
            cfg_d.neg = rate_wdata[RATE_W-1:FLD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{fam: FAM_48K, inc: '0, neg: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Modulus recovered modulo 2^FLD_W from the packed upper field
    logic [FLD_W-1:0] mod_w;
    assign mod_w = cfg_q.inc - cfg_q.neg - FLD_W'(1);

    assign fam_o = cfg_q.fam;
    assign inc_o = cfg_q.inc;
    assign mod_o = mod_w;
    assign en_o  = (mod_w != '0) && (cfg_q.inc <= mod_w);
    assign clr_o = sel_we | rate_we;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_we) && !$past(rate_we) |-> $stable(inc_o) && $stable(fam_o)) // R6
        else $error("configuration changed without a write");

endmodule

// File: rtl/sclk_tick_sel.sv
module sclk_tick_sel
    import sclk_pkg::*;
#(
    parameter int unsigned N_MASTER = 2
) (
    input  logic [N_MASTER-1:0] tick_i,
    input  fam_e                fam_i,
    output logic                tick_o
);

    logic [N_MASTER-1:0] hit;

    for (genvar g = 0; g < N_MASTER; g++) begin : g_lane
        assign hit[g] = tick_i[g] && (int'(fam_i) == g);
    end

    assign tick_o = |hit;

    always_comb begin
        if (tick_i == '0) begin
            AST_NO_PHANTOM_TICK: assert (!tick_o) // R2
                else $error("tick without any master tick");
        end
    end

endmodule

// File: rtl/sclk_accum.sv
module sclk_accum #(
    parameter int unsigned FLD_W = 16,
    localparam int unsigned SUM_W = FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [FLD_W-1:0] inc_i,
    input  logic [FLD_W-1:0] mod_i,
    output logic             strobe_o
);

    typedef struct packed {
        logic [FLD_W-1:0] acc;
        logic             strobe;
    } st_t;

    st_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] mod_ext;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        sum         = {1'b0, st_q.acc} + {1'b0, inc_i};
        mod_ext     = {1'b0, mod_i};
        if (clr_i) begin
            st_d.acc = '0;
        end else if (tick_i && en_i) begin
            if (sum >= mod_ext) begin
                st_d.acc    = FLD_W'(sum - mod_ext);
                st_d.strobe = 1'b1;
            end else begin
                st_d.acc = FLD_W'(sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(tick_i) && !$past(clr_i)) // R4
        else $error("strobe without a counted tick");

    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> {1'b0, st_q.acc} < {1'b0, mod_i}) // R4
        else $error("accumulator reached the modulus");

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_i) |-> !strobe_o) // R7
        else $error("strobe while disabled");

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (st_q.acc == '0) && !strobe_o) // R6
        else $error("write did not clear the accumulator");

endmodule

// File: rtl/sclk_frac_gen.sv
module sclk_frac_gen
    import sclk_pkg::*;
#(
    parameter int unsigned FLD_W = 16,
    parameter int unsigned SEL_W = 16,
    localparam int unsigned RATE_W = 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_44k,
    input  logic              tick_48k,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic              strobe_o
);

    fam_e             fam;
    logic [FLD_W-1:0] inc;
    logic [FLD_W-1:0] modulus;
    logic             en;
    logic             clr;
    logic             tick_sel;
    logic [1:0]       ticks;

    // lane index equals the family encoding
    assign ticks = {tick_44k, tick_48k};

    sclk_cfg_regs #(
        .FLD_W (FLD_W),
        .SEL_W (SEL_W)
    ) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .fam_o      (fam),
        .inc_o      (inc),
        .mod_o      (modulus),
        .en_o       (en),
        .clr_o      (clr)
    );

    sclk_tick_sel #(
        .N_MASTER (2)
    ) i_tsel (
        .tick_i (ticks),
        .fam_i  (fam),
        .tick_o (tick_sel)
    );

    sclk_accum #(
        .FLD_W (FLD_W)
    ) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_sel),
        .clr_i    (clr),
        .en_i     (en),
        .inc_i    (inc),
        .mod_i    (modulus),
        .strobe_o (strobe_o)
    );

    AST_SEL_IGNORES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (fam == FAM_44K) && !tick_44k && !clr |=> !strobe_o) // R2
        else $error("strobe from the unselected master");

endmodule

// File: tb/test_sclk_frac_gen.sv
`timescale 1ns/1ps
module test_sclk_frac_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_44k = 1'b0;
    logic        tick_48k = 1'b0;
    logic        sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        rate_we = 1'b0;
    logic [31:0] rate_wdata = '0;
    logic        strobe_o;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned n_strobe = 0;
    bit          finished = 1'b0;

    // reference model state
    bit          m_sel = 1'b0;
    logic [15:0] m_inc = '0;
    logic [15:0] m_neg = '0;
    int unsigned m_acc = 0;

    always #2 clk = ~clk;

    sclk_frac_gen i_sclk_frac_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_44k   (tick_44k),
        .tick_48k   (tick_48k),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .strobe_o   (strobe_o)
    );

    function automatic logic [31:0] enc(input int unsigned inc, input int unsigned md);
        logic [15:0] hi;
        hi = 16'(inc - md - 1);
        return {hi, 16'(inc)};
    endfunction

    function automatic int unsigned mod_of(input logic [15:0] inc, input logic [15:0] neg);
        logic [15:0] m;
        m = inc - neg - 16'd1;
        return int'(m);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: strobe_o=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, model the rising edge, compare after it
    task automatic cyc(input logic ta, input logic tb, input logic swe, input logic [15:0] sd,
                       input logic rwe, input logic [31:0] rd, input string tag);
        logic exp;
        int unsigned md;
        int unsigned s;
        bit tk;
        @(negedge clk);
        tick_44k = ta; tick_48k = tb; sel_we = swe; sel_wdata = sd;
        rate_we = rwe; rate_wdata = rd;
        exp = 1'b0;
        if (swe || rwe) begin
            if (swe) m_sel = sd[0];
            if (rwe) begin m_inc = rd[15:0]; m_neg = rd[31:16]; end
            m_acc = 0;
        end else begin
            md = mod_of(m_inc, m_neg);
            tk = m_sel ? ta : tb;
            if (tk && md != 0 && int'(m_inc) <= md) begin
                s = m_acc + int'(m_inc);
                if (s >= md) begin m_acc = s - md; exp = 1'b1; end
                else m_acc = s;
            end
        end
        @(posedge clk);
        #1;
        check(strobe_o, exp, tag);
        if (strobe_o) n_strobe++;
    endtask

    task automatic tick_only(input logic ta, input logic tb, input string tag);
        cyc(ta, tb, 1'b0, 16'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic wr_sel(input logic [15:0] v, input string tag);
        cyc(1'b1, 1'b1, 1'b1, v, 1'b0, 32'h0, tag);
    endtask

    task automatic wr_rate(input logic [31:0] v, input string tag);
        cyc(1'b1, 1'b1, 1'b0, 16'h0, 1'b1, v, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));

        // R1: strobe low during reset and while still in reset configuration
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); tick_44k = 1'b1; tick_48k = 1'b1;
            @(posedge clk); #1;
            check(strobe_o, 1'b0, "R1 in reset");
        end
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 20; i++) tick_only(1'b1, 1'b1, "R1 after reset");

        // R5: increment 4, modulus 24 on the 48k master -> one strobe per 6 ticks
        wr_rate(enc(4, 24), "R3 write");
        n_strobe = 0;
        for (int i = 0; i < 60; i++) tick_only(1'($urandom_range(0, 1)), 1'b1, "R5 4/24");
        total++;
        if (n_strobe != 10) begin
            bad++;
            $display("FAIL R5: strobes=%0d expected=10", n_strobe);
        end

        // R2: switch to 44k; 48k ticks alone must not count; upper selector bits ignored
        wr_sel(16'hFFFF, "R2 write sel");
        for (int i = 0; i < 30; i++) tick_only(1'b0, 1'b1, "R2 unselected 48k");
        for (int i = 0; i < 30; i++) tick_only(1'b1, 1'($urandom_range(0, 1)), "R2 selected 44k");
        wr_sel(16'hFFFE, "R2 write sel 0");
        for (int i = 0; i < 30; i++) tick_only(1'b1, 1'b0, "R2 unselected 44k");

        // R6: write mid-count clears; tick in write cycle swallowed
        wr_rate(enc(4, 8), "R6 write");
        tick_only(1'b0, 1'b1, "R6 first tick");
        wr_sel(16'h0000, "R6 rewrite sel");
        tick_only(1'b0, 1'b1, "R6 restart tick");
        tick_only(1'b0, 1'b1, "R6 restart strobe");

        // R7: zero modulus, then increment above modulus
        wr_rate(enc(4, 0), "R7 write zero mod");
        for (int i = 0; i < 20; i++) tick_only(1'b1, 1'b1, "R7 zero modulus");
        wr_rate(enc(5, 3), "R7 write inc>mod");
        for (int i = 0; i < 20; i++) tick_only(1'b1, 1'b1, "R7 inc above mod");

        // R8: increment equals modulus -> every tick strobes
        wr_rate(enc(7, 7), "R8 write");
        for (int i = 0; i < 12; i++) tick_only(1'b0, 1'b1, "R8 back to back");

        // R4 / R3: random programming and ticks
        for (int seg = 0; seg < 40; seg++) begin
            int unsigned inc;
            int unsigned md;
            inc = $urandom_range(1, 12);
            md  = inc + $urandom_range(0, 60);
            if (seg % 9 == 4) md = 0;
            if (seg % 11 == 6) md = inc - 1;
            wr_sel(16'($urandom()), "R2 random sel");
            wr_rate(enc(inc, md), "R3 random rate");
            for (int i = 0; i < 60; i++) begin
                if ($urandom_range(0, 40) == 0)
                    wr_rate(enc(inc, md), "R6 random rewrite");
                else
                    tick_only(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 random");
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule